// File: doc/BRIEF.md
# Register-Driven SPI Flash Command Sequencer

This block is an SPI flash master driven through a window of eight byte-wide registers. The host first loads an opcode, the low sixteen address bits and up to four payload bytes. It then writes a mode byte. That single write starts one serial frame. The upper nibble of the mode byte selects one of eleven fixed frame shapes. Each shape is built from a command byte, three address bytes, an optional dummy byte, write bytes and read bytes. The lower nibble supplies address bits 19:16, so the address on the wire is a 20-bit value zero-extended to three bytes. Bytes received during the read phase are stored in the data registers, where the host can read them back.

The serial side runs in SPI mode 0 and sends the most significant bit first. The serial clock is the system clock divided by a fixed even parameter. Chip select stays low for the whole frame. A busy output covers the frame and a short recovery gap after it. While busy is high, every host write is discarded. The host may therefore start a frame and read the results once busy drops, or once a known fixed time has passed. No other status is polled.

Top module: `spi_cmd_master`

## Requirements
- R1: The window has eight byte registers, all reset to 0x00. The offsets are: 0 opcode, 1 mode, 2 address bits 15:8, 3 address bits 7:0, 4 to 7 data bytes 0 to 3. While idle, a write to any offset other than 1 stores the byte, and `rd_data` returns the register selected by `rd_addr` in the same cycle.
- R2: A write to offset 1 while idle whose upper nibble is 1 to 11 stores the mode byte and starts a frame. `busy` is high and `spi_cs_n` is low from the clock edge that accepts the write.
- R3: A write to offset 1 whose upper nibble is 0 or 12 to 15 starts nothing. `busy` stays low and the mode register keeps its old value.
- R4: Each frame sends the opcode first. If the mode carries an address, three address bytes follow: {4'b0000, mode[3:0]}, offset 2, offset 3. The byte sequences per mode are:
  - 1: opcode only.
  - 2: opcode and one write byte.
  - 3: opcode and two reads.
  - 4: opcode and address.
  - 5: opcode, address and one write byte.
  - 6: opcode, address and four write bytes.
  - 7: opcode, address, one 0x00 dummy byte and four reads.
  - 8 to 11: opcode, address and 1 to 4 reads.
  
  Write bytes come from offsets 4 upward. MOSI carries 0x00 during read bytes.
- R5: Read byte k of a frame is stored at offset 4+k. Data offsets that the frame does not read keep their values.
- R6: The serial link runs in SPI mode 0, MSB first. `spi_sck` is low whenever `spi_cs_n` is high. MOSI changes only while `spi_sck` is low. MISO is sampled on the rising edge.
- R7: `spi_cs_n` stays low for the whole frame, which carries exactly 8 SCK pulses per byte.
- R8: While `busy` is high, host writes to any offset are ignored, including a write to the mode offset.
- R9: `spi_cs_n` stays high for at least CLK_DIV system cycles between frames. A mode write issued in the first idle cycle gives a gap of exactly CLK_DIV+1 cycles.
- R10: The SCK period is CLK_DIV system cycles. `busy` stays high for exactly (16*B+3)*CLK_DIV/2 cycles for a B-byte frame. At the default setting this is 294 cycles for the nine-byte frame, well under 10 microseconds at 250 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Host write offset |
| wr_data | input | 8 | Host write byte |
| rd_addr | input | 3 | Host read offset |
| rd_data | output | 8 | Register selected by rd_addr |
| busy | output | 1 | Frame in progress or chip-select recovery pending |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A host write and the end of a frame can fall in the same cycle. The write lock must therefore switch off on exactly the edge where busy drops, and not one cycle early. The bench provokes this in two ways. In the first, it writes random offsets and data, including valid mode codes, on every cycle while busy is high, up to the very last busy cycle. It then expects the opcode, address and payload registers to be unchanged, the read bytes to equal the slave's bytes, and no second frame to start. In the second, it issues a new mode write in the first cycle after busy falls. It expects that frame to start and to be separated from the previous one by exactly CLK_DIV+1 cycles of chip select high.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;

  localparam int REG_CNT  = 8;
  localparam int WIN_AW   = 3;
  localparam int DATA_CNT = 4;

  localparam int OFS_OPC  = 0;
  localparam int OFS_MODE = 1;
  localparam int OFS_AHI  = 2;
  localparam int OFS_ALO  = 3;
  localparam int OFS_DAT  = 4;

  typedef logic [REG_CNT-1:0][7:0] regfile_t;

  typedef struct packed {
    logic       valid;
    logic [3:0] n_addr;
    logic [3:0] n_dummy;
    logic [3:0] n_wr;
    logic [3:0] n_rd;
  } frame_shape_t;

  function automatic frame_shape_t shape_of(input logic [3:0] code);
    frame_shape_t s;
    s = '0;
    s.valid = 1'b1;
    case (code)
      4'h1: ;
      4'h2: s.n_wr = 4'd1;
      4'h3: s.n_rd = 4'd2;
      4'h4: s.n_addr = 4'd3;
      4'h5: begin s.n_addr = 4'd3; s.n_wr = 4'd1; end
      4'h6: begin s.n_addr = 4'd3; s.n_wr = 4'd4; end
      4'h7: begin s.n_addr = 4'd3; s.n_dummy = 4'd1; s.n_rd = 4'd4; end
      4'h8, 4'h9, 4'hA, 4'hB: begin
        s.n_addr = 4'd3;
        s.n_rd   = code - 4'h7;
      end
      default: s.valid = 1'b0;
    endcase
    return s;
  endfunction

  function automatic logic [3:0] frame_len(input frame_shape_t s);
    return 4'd1 + s.n_addr + s.n_dummy + s.n_wr + s.n_rd;
  endfunction

  function automatic logic [3:0] read_base(input frame_shape_t s);
    return 4'd1 + s.n_addr + s.n_dummy + s.n_wr;
  endfunction

endpackage

// File: rtl/spi_cmd_clkdiv.sv
`timescale 1ns/1ps
module spi_cmd_clkdiv #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_cmd_shift.sv
`timescale 1ns/1ps
module spi_cmd_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shift_en,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       miso,
  output logic       sck,
  output logic       tx_bit,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  logic [7:0] tx_q, tx_d, rx_q, rx_d;
  logic [2:0] bc_q, bc_d;
  logic       sck_q, sck_d;

  assign sck       = sck_q;
  assign tx_bit    = tx_q[7];
  assign rx_byte   = rx_q;
  assign byte_done = shift_en && tick && sck_q && (bc_q == 3'd7);

  always_comb begin
    tx_d  = tx_q;
    rx_d  = rx_q;
    bc_d  = bc_q;
    sck_d = sck_q;
    if (shift_en && tick) begin
      if (!sck_q) begin
        sck_d = 1'b1;
        rx_d  = {rx_q[6:0], miso};
      end else begin
        sck_d = 1'b0;
        if (bc_q != 3'd7) begin
          tx_d = {tx_q[6:0], 1'b0};
          bc_d = bc_q + 3'd1;
        end
      end
    end
    if (load) begin
      tx_d  = load_byte;
      bc_d  = 3'd0;
      sck_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q  <= '0;
      rx_q  <= '0;
      bc_q  <= '0;
      sck_q <= 1'b0;
    end else begin
      tx_q  <= tx_d;
      rx_q  <= rx_d;
      bc_q  <= bc_d;
      sck_q <= sck_d;
    end
  end
endmodule

// File: rtl/spi_cmd_regs.sv
`timescale 1ns/1ps
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WIN_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic              st_en,
  input  logic [1:0]        st_idx,
  input  logic [7:0]        st_data,
  input  logic [WIN_AW-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output regfile_t          regs_flat,
  output logic              start
);
  logic [7:0]   regs_q [REG_CNT];
  logic [7:0]   regs_d [REG_CNT];
  frame_shape_t wr_shape;
  logic         mode_sel, host_ok;

  always_comb wr_shape = shape_of(wr_data[7:4]);

  assign mode_sel = (wr_addr == WIN_AW'(OFS_MODE));
  assign start    = wr_en && !busy && mode_sel && wr_shape.valid;
  assign host_ok  = wr_en && !busy && (!mode_sel || wr_shape.valid);
  assign rd_data  = regs_q[rd_addr];

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    assign regs_flat[g] = regs_q[g];

    if (g >= OFS_DAT) begin : g_data
      always_comb begin
        regs_d[g] = regs_q[g];
        if (host_ok && wr_addr == WIN_AW'(g))
          regs_d[g] = wr_data;
        else if (st_en && st_idx == 2'(g - OFS_DAT))
          regs_d[g] = st_data;
      end
    end else begin : g_ctrl
      always_comb begin
        regs_d[g] = regs_q[g];
        if (host_ok && wr_addr == WIN_AW'(g))
          regs_d[g] = wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= '0;
      else        regs_q[g] <= regs_d[g];
    end
  end
endmodule

// File: rtl/spi_cmd_fsm.sv
`timescale 1ns/1ps
module spi_cmd_fsm
  import spi_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] start_code,
  input  regfile_t   regs,
  input  logic       tick,
  input  logic       byte_done,
  input  logic [7:0] rx_byte,
  output logic       busy,
  output logic       shift_en,
  output logic       cs_n,
  output logic       load,
  output logic [7:0] load_byte,
  output logic       st_en,
  output logic [1:0] st_idx,
  output logic [7:0] st_data
);
  typedef enum logic [1:0] {S_IDLE, S_XFER, S_TAIL, S_GAP} state_t;

  state_t       state_q, state_d;
  logic [3:0]   idx_q, idx_d;
  logic [3:0]   nib_q, nib_d;
  frame_shape_t shp_q, shp_d;
  logic         gap_q, gap_d;
  logic [3:0]   len, rbase;

  function automatic logic [7:0] pick(input logic [3:0] idx,
                                      input frame_shape_t s,
                                      input logic [3:0] nib,
                                      input regfile_t r);
    logic [3:0] pos;
    pos = idx - 4'd1 - s.n_addr - s.n_dummy;
    if (idx == 4'd0)                         return r[OFS_OPC];
    if (idx <= s.n_addr) begin
      case (idx)
        4'd1:    return {4'h0, nib};
        4'd2:    return r[OFS_AHI];
        default: return r[OFS_ALO];
      endcase
    end
    if (idx < 4'd1 + s.n_addr + s.n_dummy)   return 8'h00;
    if (pos < s.n_wr)                        return r[OFS_DAT + int'(pos[1:0])];
    return 8'h00;
  endfunction

  assign len      = frame_len(shp_q);
  assign rbase    = read_base(shp_q);
  assign busy     = (state_q != S_IDLE);
  assign shift_en = (state_q == S_XFER);
  assign cs_n     = !((state_q == S_XFER) || (state_q == S_TAIL));
  assign st_en    = shift_en && byte_done && (idx_q >= rbase);
  assign st_idx   = 2'(idx_q - rbase);
  assign st_data  = rx_byte;

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    nib_d     = nib_q;
    shp_d     = shp_q;
    gap_d     = gap_q;
    load      = 1'b0;
    load_byte = regs[OFS_OPC];
    case (state_q)
      S_IDLE: if (start) begin
        state_d = S_XFER;
        idx_d   = 4'd0;
        shp_d   = shape_of(start_code[7:4]);
        nib_d   = start_code[3:0];
        load    = 1'b1;
      end
      S_XFER: if (byte_done) begin
        if (idx_q == len - 4'd1) begin
          state_d = S_TAIL;
        end else begin
          idx_d     = idx_q + 4'd1;
          load      = 1'b1;
          load_byte = pick(idx_q + 4'd1, shp_q, nib_q, regs);
        end
      end
      S_TAIL: if (tick) begin
        state_d = S_GAP;
        gap_d   = 1'b0;
      end
      default: if (tick) begin
        if (gap_q) state_d = S_IDLE;
        else       gap_d   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      nib_q   <= '0;
      shp_q   <= '0;
      gap_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      nib_q   <= nib_d;
      shp_q   <= shp_d;
      gap_q   <= gap_d;
    end
  end
endmodule

// File: rtl/spi_cmd_master.sv
`timescale 1ns/1ps
module spi_cmd_master
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WIN_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [WIN_AW-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int HALF = CLK_DIV / 2;

  if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
    $error("CLK_DIV must be even and at least 2");
  end

  logic [1:0] rsync_q;
  logic       rst_sync_n;
  regfile_t   regs_q;
  logic       start, tick, byte_done, shift_en, load, st_en, tx_bit;
  logic [7:0] load_byte, rx_byte, st_data;
  logic [1:0] st_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  spi_cmd_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .st_en(st_en), .st_idx(st_idx),
    .st_data(st_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .regs_flat(regs_q), .start(start)
  );

  spi_cmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .start_code(wr_data),
    .regs(regs_q), .tick(tick), .byte_done(byte_done), .rx_byte(rx_byte),
    .busy(busy), .shift_en(shift_en), .cs_n(spi_cs_n), .load(load),
    .load_byte(load_byte), .st_en(st_en), .st_idx(st_idx), .st_data(st_data)
  );

  spi_cmd_clkdiv #(.HALF(HALF)) u_div (
    .clk(clk), .rst_n(rst_sync_n), .run(busy), .tick(tick)
  );

  spi_cmd_shift u_shift (
    .clk(clk), .rst_n(rst_sync_n), .shift_en(shift_en), .tick(tick),
    .load(load), .load_byte(load_byte), .miso(spi_miso), .sck(spi_sck),
    .tx_bit(tx_bit), .byte_done(byte_done), .rx_byte(rx_byte)
  );

  assign spi_mosi = shift_en & tx_bit;
endmodule

// File: rtl/spi_cmd_chk.sv
`timescale 1ns/1ps
module spi_cmd_chk
  import spi_cmd_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [WIN_AW-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              busy,
  input logic              sck,
  input logic              cs_n,
  input logic              mosi,
  input regfile_t          regs
);
  localparam int GW = $clog2(CLK_DIV + 2) + 1;

  frame_shape_t code_shape;
  logic         mode_wr;
  logic [GW-1:0] high_cnt;

  always_comb code_shape = shape_of(wr_data[7:4]);
  assign mode_wr = wr_en && !busy && (wr_addr == WIN_AW'(OFS_MODE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      high_cnt <= GW'(CLK_DIV);
    else if (!cs_n)                  high_cnt <= '0;
    else if (high_cnt < GW'(CLK_DIV)) high_cnt <= high_cnt + 1'b1;
  end

  // R2
  start_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && code_shape.valid |=> busy && !cs_n);

  // R3
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr && !code_shape.valid |=> !busy && $stable(regs[OFS_MODE]));

  // R6
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));

  // R7
  cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  // R8
  busy_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en |=> $stable(regs[3:0]));

  // R9
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> high_cnt >= GW'(CLK_DIV));
endmodule

bind spi_cmd_master spi_cmd_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .busy(busy), .sck(spi_sck), .cs_n(spi_cs_n),
  .mosi(spi_mosi), .regs(regs_q)
);

// File: tb/spi_cmd_master_test.sv
`timescale 1ns/1ps
module spi_cmd_master_test;
  localparam int CLK_DIV = 4;
  localparam int HALF    = CLK_DIV / 2;

  logic       clk = 1'b0;
  logic       rst_n, wr_en, busy, spi_sck, spi_cs_n, spi_mosi, spi_miso;
  logic [2:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  int n_chk = 0, n_bad = 0;
  int frames = 0, sbits = 0, sck_idle_bad = 0, period_bad = 0;
  int last_gap = 0, min_gap = 1000;
  bit have_rise = 0;
  time rise_t = 0, last_sck = 0;
  logic [7:0] resp [16];
  logic [7:0] mlog [16];
  logic [7:0] sh [8];

  always #2 clk = ~clk;  // 4 ns period, 250 MHz

  spi_cmd_master #(.CLK_DIV(CLK_DIV)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  // SPI mode 0 flash model: captures MOSI on rise, drives MISO after fall
  always @(negedge spi_cs_n) begin
    sbits    = 0;
    spi_miso = resp[0][7];
    last_sck = 0;
    if (have_rise) begin
      last_gap = int'(($time - rise_t) / 4);
      if (last_gap < min_gap) min_gap = last_gap;
    end
  end
  always @(posedge spi_cs_n) begin
    frames++;
    rise_t    = $time;
    have_rise = 1;
  end
  always @(posedge spi_sck) if (!spi_cs_n && sbits < 128) begin
    mlog[sbits/8][7-(sbits%8)] = spi_mosi;
    sbits++;
    if (last_sck != 0 && int'(($time - last_sck) / 4) != CLK_DIV) period_bad++;
    last_sck = $time;
  end
  always @(negedge spi_sck) if (!spi_cs_n && sbits < 128)
    spi_miso = resp[sbits/8][7-(sbits%8)];
  always @(negedge clk) if (rst_n && spi_cs_n && spi_sck) sck_idle_bad++;

  task automatic chk(input bit good, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic void shape(input logic [3:0] c, output bit ok,
                                output int na, output int nd,
                                output int nw, output int nr);
    ok = 1; na = 0; nd = 0; nw = 0; nr = 0;
    case (c)
      4'd1: ;
      4'd2: nw = 1;
      4'd3: nr = 2;
      4'd4: na = 3;
      4'd5: begin na = 3; nw = 1; end
      4'd6: begin na = 3; nw = 4; end
      4'd7: begin na = 3; nd = 1; nr = 4; end
      4'd8, 4'd9, 4'd10, 4'd11: begin na = 3; nr = int'(c) - 7; end
      default: ok = 0;
    endcase
  endfunction

  // called at a falling edge, returns at the next falling edge
  task automatic host_write(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_all(input string tag_ctl);
    for (int o = 0; o < 8; o++) begin
      rd_addr = 3'(o);
      #1;
      chk(rd_data == sh[o], (o >= 4) ? "R5" : ((o == 1) ? tag_ctl : "R1"),
          $sformatf("offset %0d readback", o), rd_data, sh[o]);
    end
    @(negedge clk);
  endtask

  task automatic run_txn(input logic [7:0] m, input bit hammer);
    bit ok; int na, nd, nw, nr, nb, base, n, k, f0;
    logic [7:0] expb [16];
    for (int o = 0; o < 8; o++) if (o != 1) begin
      logic [7:0] v;
      v = 8'($urandom);
      host_write(3'(o), v);
      sh[o] = v;
    end
    for (int i = 0; i < 16; i++) resp[i] = 8'($urandom);
    shape(m[7:4], ok, na, nd, nw, nr);
    f0 = frames;
    host_write(3'd1, m);
    if (ok) begin
      chk(busy === 1'b1, "R2", "busy after mode write", busy, 1);
      nb = 1 + na + nd + nw + nr;
      base = 1 + na + nd + nw;
      k = 0;
      expb[k++] = sh[0];
      if (na != 0) begin
        expb[k++] = {4'h0, m[3:0]}; expb[k++] = sh[2]; expb[k++] = sh[3];
      end
      for (int i = 0; i < nd; i++) expb[k++] = 8'h00;
      for (int i = 0; i < nw; i++) expb[k++] = sh[4+i];
      for (int i = 0; i < nr; i++) expb[k++] = 8'h00;
      n = 0;
      while (busy === 1'b1 && n < 5000) begin
        n++;
        if (hammer) begin
          wr_en = 1'b1; wr_addr = 3'($urandom); wr_data = 8'($urandom);
        end
        @(negedge clk);
      end
      wr_en = 1'b0;
      chk(n == (16*nb+3)*HALF, "R10", "busy length", n, (16*nb+3)*HALF);
      chk(frames == f0 + 1, "R7", "frame count", frames - f0, 1);
      chk(sbits == 8*nb, "R7", "SCK pulses", sbits, 8*nb);
      for (int i = 0; i < nb; i++)
        chk(mlog[i] == expb[i], "R4", $sformatf("mode %0h byte %0d", m[7:4], i),
            mlog[i], expb[i]);
      sh[1] = m;
      for (int i = 0; i < nr; i++) sh[4+i] = resp[base+i];
      if (hammer) begin
        repeat (4*CLK_DIV) @(negedge clk);
        chk(frames == f0 + 1 && busy === 1'b0, "R8", "no frame from locked write",
            frames - f0, 1);
      end
      read_all(hammer ? "R8" : "R2");
    end else begin
      n = 0;
      repeat (4*CLK_DIV) begin
        if (busy !== 1'b0) n++;
        @(negedge clk);
      end
      chk(n == 0, "R3", "busy cycles after bad code", n, 0);
      chk(frames == f0, "R3", "frames after bad code", frames - f0, 0);
      read_all("R3");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7151));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    spi_miso = 1'b0;
    for (int i = 0; i < 16; i++) resp[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    frames = 0; have_rise = 0; min_gap = 1000; sck_idle_bad = 0;

    // R1 reset state
    chk(busy === 1'b0, "R1", "busy at reset", busy, 0);
    chk(spi_cs_n === 1'b1, "R1", "cs_n at reset", spi_cs_n, 1);
    chk(spi_sck === 1'b0, "R1", "sck at reset", spi_sck, 0);
    for (int o = 0; o < 8; o++) sh[o] = 8'h00;
    read_all("R1");

    // R4 R5 every mode, directed
    for (int c = 1; c <= 11; c++) run_txn({4'(c), 4'($urandom)}, 1'b0);
    // R3 every rejected code
    run_txn(8'h0F, 1'b0);
    for (int c = 12; c <= 15; c++) run_txn({4'(c), 4'h3}, 1'b0);
    // R8 writes hammered through the whole frame, read modes and a write mode
    run_txn(8'hB5, 1'b1);
    run_txn(8'h7A, 1'b1);
    run_txn(8'h6C, 1'b1);
    // random mix
    for (int t = 0; t < 40; t++) run_txn(8'($urandom), 1'b0);

    // R9 back-to-back: new mode write in the first idle cycle
    host_write(3'd1, 8'h10);
    while (busy === 1'b1) @(negedge clk);
    host_write(3'd1, 8'h10);
    while (busy === 1'b1) @(negedge clk);
    chk(last_gap == CLK_DIV + 1, "R9", "back-to-back cs_n gap", last_gap, CLK_DIV + 1);
    chk(min_gap >= CLK_DIV, "R9", "minimum cs_n gap", min_gap, CLK_DIV);
    chk(sck_idle_bad == 0, "R6", "sck high with cs_n high", sck_idle_bad, 0);
    chk(period_bad == 0, "R10", "SCK period deviations", period_bad, 0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule